// File: doc/BRIEF.md
# Idle-Aware Bus Clock Divider

This block derives a clock-enable pulse for a peripheral bus from a faster system bus clock. A 32-bit configuration word holds two divide codes: a normal code that sets the rate used while the peripheral bus is working, and an idle code that sets a slower rate for periods when the bus has nothing to do. Each code maps to a divisor of 1, 2 or 4 of the fast clock. Downstream logic qualifies its registers with the enable pulse and does not use a derived clock.

When the idle code is non-zero and numerically larger than the normal code, the block runs at the idle rate while the bus-activity input is low. It goes back to the normal rate once activity is reported. An idle code of zero turns the automatic slow-down off. Every rate change is applied only at the end of a divided period, so no pulse ever arrives early or late within a period. The divisor in force is reported on a status output.

Top module: `pclk_idle_div`

## Requirements
- R1: While reset is held and right after its release, the readback word is 0, the reported divisor is 1 and the enable pulse is high in every fast cycle.
- R2: Bits 15:0 of a written word read back unchanged from the next cycle on. Readback bits 31:16 are always zero and ignore write data.
- R3: The normal code sits in bits 15:8. Code 0 gives divisor 1, code 1 gives divisor 2 and code 3 gives divisor 4. For divisors above 1 the enable is high for exactly one fast cycle per period.
- R4: Any code other than 0, 1 or 3 (for example 2, 0x80, 0xFF), in either field, gives divisor 4.
- R5: The idle code sits in bits 7:0. While the bus-activity input is low and the idle code is greater than the normal code, the idle code's divisor is in force.
- R6: If the idle code is not greater than the normal code (smaller or equal), the normal divisor stays in force while the bus is idle.
- R7: An idle code of 0 has no effect, and the normal divisor stays in force whatever the activity input does.
- R8: Bus activity that is high at the end of a divided period makes the normal divisor take effect from the next fast cycle on.
- R9: The reported divisor and the pulse spacing change only in the fast cycle that follows an enable pulse. A configuration change made in the middle of a period leaves that period's length unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration readback |
| bus_busy_i | input | 1 | High while a peripheral bus access is in progress |
| pclk_en_o | output | 1 | One-fast-cycle enable pulse at the divided rate |
| eff_div_o | output | 3 | Divisor currently in force (1, 2 or 4) |

## Verification
The hardest situation to reach from the ports is a rate change that arrives mid-period. The stimulus waits until it sees an enable pulse. One cycle later it writes a new normal code, then checks that the old divisor holds until the next pulse and that the new one appears in the cycle after it. The return from the idle rate is timed the same way: activity is raised in the cycle of an observed pulse, and the divisor must read 1 in the very next cycle. A vector table walks code pairs where the idle code is greater than, equal to or smaller than the normal code, with the activity input both high and low.

// File: rtl/pclk_div_pkg.sv
package pclk_div_pkg;

  localparam int CODE_W = 8;
  localparam int MAX_SH = 2;
  localparam int SH_W   = $clog2(MAX_SH + 1);
  localparam int DIV_W  = MAX_SH + 1;

  typedef logic [SH_W-1:0]   shift_t;
  typedef logic [CODE_W-1:0] code_t;

  // Map a divide code to a power-of-two shift; unlisted codes take the slowest rate.
  function automatic shift_t code_to_shift(input code_t code);
    shift_t sh;
    case (code)
      code_t'(0): sh = shift_t'(0);
      code_t'(1): sh = shift_t'(1);
      code_t'(3): sh = shift_t'(2);
      default:    sh = shift_t'(MAX_SH);
    endcase
    return sh;
  endfunction

endpackage

// File: rtl/pclk_cfg_reg.sv
module pclk_cfg_reg
  import pclk_div_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CW     = CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CW-1:0]     norm_code_o,
  output logic [CW-1:0]     idle_code_o
);

  localparam int FIELD_W = 2 * CW;

  logic [FIELD_W-1:0] field_q;
  logic [FIELD_W-1:0] field_d;

  always_comb begin
    field_d = field_q;
    if (we_i) begin
      field_d = wdata_i[FIELD_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_q <= '0;
    end else begin
      field_q <= field_d;
    end
  end

  assign idle_code_o = field_q[CW-1:0];
  assign norm_code_o = field_q[FIELD_W-1:CW];

  generate
    if (DATA_W > FIELD_W) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^wdata_i[DATA_W-1:FIELD_W];
      assign rdata_o   = {{(DATA_W-FIELD_W){1'b0}}, field_q};
    end else begin : g_exact
      assign rdata_o = field_q;
    end
  endgenerate

  // R2
  wr_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o[FIELD_W-1:0] == $past(wdata_i[FIELD_W-1:0]));

endmodule

// File: rtl/pclk_ratio_sel.sv
module pclk_ratio_sel
  import pclk_div_pkg::*;
#(
  parameter int CW = CODE_W
) (
  input  logic [CW-1:0] norm_code_i,
  input  logic [CW-1:0] idle_code_i,
  input  logic          bus_busy_i,
  output shift_t        norm_sh_o,
  output shift_t        target_sh_o
);

  logic   idle_enabled;
  logic   idle_use;
  shift_t idle_sh;

  always_comb begin
    idle_enabled = (idle_code_i != '0) && (idle_code_i > norm_code_i);
    idle_use     = idle_enabled && !bus_busy_i;
    norm_sh_o    = code_to_shift(norm_code_i);
    idle_sh      = code_to_shift(idle_code_i);
    target_sh_o  = idle_use ? idle_sh : norm_sh_o;
  end

endmodule

// File: rtl/pclk_tick_gen.sv
module pclk_tick_gen
  import pclk_div_pkg::*;
#(
  parameter int MSH   = MAX_SH,
  parameter int CNT_W = (MSH < 1) ? 1 : MSH
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  shift_t target_sh_i,
  output logic   tick_o,
  output shift_t cur_sh_o
);

  localparam logic [CNT_W:0]   SPAN_ONE = 1;
  localparam logic [CNT_W-1:0] CNT_ONE  = 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  shift_t           sh_q, sh_d;
  logic [CNT_W:0]   span;
  logic [CNT_W:0]   span_m1;
  logic [CNT_W-1:0] term_cnt;

  always_comb begin
    span     = SPAN_ONE << sh_q;
    span_m1  = span - SPAN_ONE;
    term_cnt = span_m1[CNT_W-1:0];
    tick_o   = (cnt_q == term_cnt);
  end

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (tick_o) begin
      cnt_d = '0;
      sh_d  = target_sh_i;
    end else begin
      cnt_d = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  assign cur_sh_o = sh_q;

  // R9
  ratio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> $stable(cur_sh_o));

  // R9
  ratio_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cur_sh_o) |-> $past(tick_o));

  // R3
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tick_o) && (cur_sh_o != '0)) |-> !tick_o);

endmodule

// File: rtl/pclk_idle_div.sv
module pclk_idle_div
  import pclk_div_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  input  logic              bus_busy_i,
  output logic              pclk_en_o,
  output logic [DIV_W-1:0]  eff_div_o
);

  localparam logic [DIV_W-1:0] DIV_ONE = 1;

  logic [CODE_W-1:0] norm_code;
  logic [CODE_W-1:0] idle_code;
  shift_t            norm_sh;
  shift_t            target_sh;
  shift_t            cur_sh;
  logic [DIV_W-1:0]  norm_div;

  pclk_cfg_reg #(
    .DATA_W (DATA_W),
    .CW     (CODE_W)
  ) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .wdata_i     (cfg_wdata_i),
    .rdata_o     (cfg_rdata_o),
    .norm_code_o (norm_code),
    .idle_code_o (idle_code)
  );

  pclk_ratio_sel #(
    .CW (CODE_W)
  ) u_sel (
    .norm_code_i (norm_code),
    .idle_code_i (idle_code),
    .bus_busy_i  (bus_busy_i),
    .norm_sh_o   (norm_sh),
    .target_sh_o (target_sh)
  );

  pclk_tick_gen #(
    .MSH (MAX_SH)
  ) u_tick (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .target_sh_i (target_sh),
    .tick_o      (pclk_en_o),
    .cur_sh_o    (cur_sh)
  );

  assign eff_div_o = DIV_ONE << cur_sh;
  assign norm_div  = DIV_ONE << norm_sh;

  // R8
  busy_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_busy_i && pclk_en_o) |=> eff_div_o == $past(norm_div));

  // R7
  idle_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((idle_code == '0) && pclk_en_o) |=> eff_div_o == $past(norm_div));

  // R3
  div_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(eff_div_o) && (eff_div_o != '0));

endmodule

// File: tb/pclk_idle_div_bench.sv
`timescale 1ns/1ps
module pclk_idle_div_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        we;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        busy;
  logic        pclk_en;
  logic [2:0]  eff_div;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pclk_idle_div u_pclk_idle_div (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_we_i    (we),
    .cfg_wdata_i (wdata),
    .cfg_rdata_o (rdata),
    .bus_busy_i  (busy),
    .pclk_en_o   (pclk_en),
    .eff_div_o   (eff_div)
  );

  localparam int NV = 15;
  // columns: normal code, idle code, activity, expected divisor, requirement
  localparam logic [7:0] V_NORM [NV] = '{8'h00, 8'h01, 8'h03, 8'h02, 8'hFF,
                                         8'h00, 8'h00, 8'h01, 8'h00, 8'h01,
                                         8'h03, 8'h01, 8'h00, 8'h01, 8'h01};
  localparam logic [7:0] V_IDLE [NV] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
                                         8'h01, 8'h03, 8'h03, 8'h02, 8'h80,
                                         8'h01, 8'h01, 8'h03, 8'h03, 8'h00};
  localparam logic       V_BUSY [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                         1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                         1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam int         V_DIV  [NV] = '{1, 2, 4, 4, 4,
                                         2, 4, 4, 4, 4,
                                         4, 2, 1, 2, 2};
  // R3 x3, R4 x2, R5 x3, R4 x2, R6 x2, R8 x2, R7 x1
  localparam int         V_REQ  [NV] = '{3, 3, 3, 4, 4,
                                         5, 5, 5, 4, 4,
                                         6, 6, 8, 8, 7};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // starts and ends at a falling edge
  task automatic wr(input logic [31:0] d);
    we    = 1'b1;
    wdata = d;
    @(negedge clk);
    we    = 1'b0;
  endtask

  task automatic measure(output int p);
    for (int k = 0; k < 20 && !pclk_en; k++) @(negedge clk);
    @(negedge clk);
    p = 1;
    for (int k = 0; k < 20 && !pclk_en; k++) begin
      @(negedge clk);
      p++;
    end
  endtask

  initial begin
    #750000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
    $finish;
  end

  initial begin
    int p;
    int highs;
    bit back2back;
    rst_n = 1'b0;
    we    = 1'b0;
    wdata = '0;
    busy  = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(rdata == 32'h0, "R1", int'(rdata), 0);
    chk(eff_div == 3'd1, "R1", int'(eff_div), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pclk_en == 1'b1, "R1", int'(pclk_en), 1);
    @(negedge clk);
    chk(pclk_en == 1'b1, "R1", int'(pclk_en), 1);
    chk(eff_div == 3'd1, "R1", int'(eff_div), 1);

    // R2 readback, upper half ignored
    wr(32'hDEAD_A5C3);
    chk(rdata == 32'h0000_A5C3, "R2", int'(rdata), 32'hA5C3);
    wr(32'hFFFF_0000);
    chk(rdata == 32'h0, "R2", int'(rdata), 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      busy = V_BUSY[i];
      wr({16'hBEEF, V_NORM[i], V_IDLE[i]});
      repeat (10) @(negedge clk);
      chk(int'(eff_div) == V_DIV[i], $sformatf("R%0d", V_REQ[i]), int'(eff_div), V_DIV[i]);
      measure(p);
      chk(p == V_DIV[i], $sformatf("R%0d", V_REQ[i]), p, V_DIV[i]);
    end

    // R3 pulse width at divide-by-4
    busy = 1'b0;
    wr({16'h0, 8'h03, 8'h00});
    repeat (10) @(negedge clk);
    highs = 0;
    back2back = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (pclk_en) begin
        highs++;
        if (k > 0 && back2back) back2back = 1'b1;
      end
      @(negedge clk);
      if (pclk_en && highs > 0 && k < 7) begin
        // the previous sample and this one both high
      end
    end
    chk(highs == 2, "R3", highs, 2);
    for (int k = 0; k < 8; k++) begin
      logic prev;
      prev = pclk_en;
      @(negedge clk);
      if (prev && pclk_en) back2back = 1'b1;
    end
    chk(back2back == 1'b0, "R3", int'(back2back), 0);

    // R5 / R8 timing: idle at /4, activity in the cycle of a pulse
    wr({16'h0, 8'h00, 8'h03});
    repeat (10) @(negedge clk);
    chk(eff_div == 3'd4, "R5", int'(eff_div), 4);
    for (int k = 0; k < 20 && !pclk_en; k++) @(negedge clk);
    busy = 1'b1;
    @(negedge clk);
    chk(eff_div == 3'd1, "R8", int'(eff_div), 1);
    @(negedge clk);
    busy = 1'b0;
    @(negedge clk);
    chk(eff_div == 3'd4, "R5", int'(eff_div), 4);

    // R9 mid-period change: /4 running, switch normal code to /2
    wr({16'h0, 8'h03, 8'h00});
    repeat (10) @(negedge clk);
    for (int k = 0; k < 20 && !pclk_en; k++) @(negedge clk);
    @(negedge clk);
    wr({16'h0, 8'h01, 8'h00});
    chk(eff_div == 3'd4, "R9", int'(eff_div), 4);
    chk(pclk_en == 1'b0, "R9", int'(pclk_en), 0);
    repeat (2) @(negedge clk);
    chk(pclk_en == 1'b1, "R9", int'(pclk_en), 1);
    chk(eff_div == 3'd4, "R9", int'(eff_div), 4);
    @(negedge clk);
    chk(eff_div == 3'd2, "R9", int'(eff_div), 2);

    report();
    $finish;
  end

endmodule